// File: doc/BRIEF.md
# Set/Clear/Toggle Aliased Register Bank

This block is a bank of 32-bit control registers on a simple word-addressed bus. Each aliased register takes a group of four consecutive words. The first word is the register itself. The other three are alias words that change only the bits that are 1 in the write data: they set them, clear them or invert them. Software can therefore change single control bits without a read-modify-write sequence and without racing another agent that uses the same word. A read from any word of a group returns the register's current value. A few plain registers follow the aliased groups. A write to a plain register replaces the whole word.

Every group has its own reset value, given as a parameter. A second parameter marks some groups as clock-generator control registers. In those groups the lock status bit is forced to 1 at reset, so software that polls for lock finds it already set. Only full-word accesses are legal. A request with any byte-enable lane low is rejected with an error flag.

A request is accepted on any clock edge where `reqValid` is high. A write updates the storage on that same edge. The response (`rspValid`, read data and the error flag) appears one cycle later.

Top module: `alias_reg_bank`

## Requirements
- R1: Group g occupies word indices 4g (register), 4g+1 (SET alias), 4g+2 (CLR alias) and 4g+3 (TOG alias). Plain register p sits at word 4*NUM_GROUPS+p. The default map has 4 groups at words 0 to 15 and plain registers at words 16 and 17.
- R2: A full-word write to a group's register word replaces its whole value.
- R3: A full-word write to a SET alias ORs the write data into the group's register.
- R4: A full-word write to a CLR alias clears every register bit that is 1 in the write data and leaves the other bits unchanged.
- R5: A full-word write to a TOG alias XORs the write data into the group's register.
- R6: A full-word read of any of the four words of a group returns the group register's current value.
- R7: A full-word write to a plain register replaces that register only, and a read returns it.
- R8: Reset loads each group with its reset value, OR-ed with bit 31 (the lock bit) for groups flagged as PLL groups, and clears the plain registers. With the default parameters, words 0, 4, 8 and 12 read 0x80013001, 0x80012000, 0x1018101B and 0x00000000.
- R9: `rspValid` is high exactly in the cycle after each accepted request. Read data belongs to that cycle. A write is visible to a read issued in the very next cycle.
- R10: A request whose `reqBe` is not 4'hF changes no register, returns zero data and raises `rspErr` together with `rspValid`.
- R11: A full-word access to a word index above the last plain register is ignored on write and reads zero, and `rspErr` stays low.
- R12: The response to a write always carries zero read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present; accepted on the rising edge |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word index (byte offset shifted right by two) |
| reqWdata | input | 32 | Write data |
| reqBe | input | 4 | Byte-lane enables; only 4'hF is a legal access |
| rspValid | output | 1 | Response for the request accepted one cycle earlier |
| rspRdata | output | 32 | Read data, or zero for writes and rejected accesses |
| rspErr | output | 1 | Request had a partial byte-enable mask |

## Verification
The bound checker covers, on every cycle and for every group, the result of each alias operation and of a direct write on the register value, the rule that a partial byte mask leaves all groups stable and flags an error, the one-cycle response timing, the zero data on write responses, and read-back of the group value through all four words. The bench scenarios are needed for the rest. They show the reset values and the forced lock bits, also after a reset in mid-run. They show plain-register isolation, silent handling of unmapped words, back-to-back write-then-read ordering, and chains of alias operations on the same register that expose an accumulated value.

// File: rtl/alias_reg_pkg.sv
package alias_reg_pkg;

  localparam int IDX_W = 8;

  // Encoding equals the word offset inside a group.
  typedef enum logic [1:0] {
    OP_BASE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TOG  = 2'd3
  } aliasOp_e;

  typedef struct packed {
    logic             wrGrp;
    logic             wrPlain;
    logic             rdGrp;
    logic             rdPlain;
    aliasOp_e         op;
    logic [IDX_W-1:0] idx;
  } bankStb_t;

  function automatic logic [31:0] applyOp(aliasOp_e op, logic [31:0] cur,
                                          logic [31:0] wd);
    case (op)
      OP_SET:  return cur | wd;
      OP_CLR:  return cur & ~wd;
      OP_TOG:  return cur ^ wd;
      default: return wd;
    endcase
  endfunction

endpackage

// File: rtl/alias_reg_decode.sv
module alias_reg_decode
  import alias_reg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_GROUPS = 4,
  parameter int NUM_PLAIN  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqBe,
  output bankStb_t          stb,
  output logic              rspValid,
  output logic              rspErr
);

  localparam int unsigned GRP_WORDS = 4 * NUM_GROUPS;
  localparam int unsigned MAP_END   = GRP_WORDS + NUM_PLAIN;

  logic [31:0] addrWord;
  logic        beOk;
  logic        inGrp;
  logic        inPlain;

  always_comb begin
    addrWord = 32'(reqAddr);
    beOk     = &reqBe;
    inGrp    = addrWord < GRP_WORDS;
    inPlain  = !inGrp && (addrWord < MAP_END);

    stb         = '0;
    stb.wrGrp   = reqValid && reqWrite && beOk && inGrp;
    stb.rdGrp   = reqValid && !reqWrite && beOk && inGrp;
    stb.wrPlain = reqValid && reqWrite && beOk && inPlain;
    stb.rdPlain = reqValid && !reqWrite && beOk && inPlain;
    if (inGrp) begin
      stb.op  = aliasOp_e'(reqAddr[1:0]);
      stb.idx = IDX_W'(addrWord >> 2);
    end else begin
      stb.op  = OP_BASE;
      stb.idx = IDX_W'(addrWord - GRP_WORDS);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspErr   <= reqValid && !beOk;
    end
  end

endmodule

// File: rtl/alias_reg_store.sv
module alias_reg_store
  import alias_reg_pkg::*;
#(
  parameter int                           NUM_GROUPS = 4,
  parameter int                           NUM_PLAIN  = 2,
  parameter int                           LOCK_BIT   = 31,
  parameter logic [NUM_GROUPS-1:0]        PLL_MASK   = '0,
  parameter logic [NUM_GROUPS-1:0][31:0]  GRP_RESET  = '0
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  bankStb_t                       stb,
  input  logic [31:0]                    wrData,
  output logic [NUM_GROUPS-1:0][31:0]    grpVal,
  output logic [31:0]                    rdData
);

  localparam logic [31:0] LOCK_MASK = 32'(1) << LOCK_BIT;

  logic [NUM_PLAIN-1:0][31:0] plainVal;
  logic [31:0]                rdNext;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGrp
    localparam logic [31:0] RST = GRP_RESET[g] | (PLL_MASK[g] ? LOCK_MASK : 32'h0);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        grpVal[g] <= RST;
      end else if (stb.wrGrp && stb.idx == IDX_W'(g)) begin
        grpVal[g] <= applyOp(stb.op, grpVal[g], wrData);
      end
    end
  end

  for (genvar p = 0; p < NUM_PLAIN; p++) begin : gPlain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        plainVal[p] <= '0;
      end else if (stb.wrPlain && stb.idx == IDX_W'(p)) begin
        plainVal[p] <= wrData;
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (stb.rdGrp) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (stb.idx == IDX_W'(g)) rdNext = grpVal[g];
      end
    end else if (stb.rdPlain) begin
      for (int p = 0; p < NUM_PLAIN; p++) begin
        if (stb.idx == IDX_W'(p)) rdNext = plainVal[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

endmodule

// File: rtl/alias_reg_bank.sv
module alias_reg_bank
  import alias_reg_pkg::*;
#(
  parameter int                          ADDR_W     = 8,
  parameter int                          NUM_GROUPS = 4,
  parameter int                          NUM_PLAIN  = 2,
  parameter int                          LOCK_BIT   = 31,
  parameter logic [NUM_GROUPS-1:0]       PLL_MASK   = 4'b0011,
  parameter logic [NUM_GROUPS-1:0][31:0] GRP_RESET  =
    {32'h0000_0000, 32'h1018_101B, 32'h0001_2000, 32'h0001_3001}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic [3:0]        reqBe,
  output logic              rspValid,
  output logic [31:0]       rspRdata,
  output logic              rspErr
);

  bankStb_t                    stb;
  logic [NUM_GROUPS-1:0][31:0] grpVal;

  alias_reg_decode #(
    .ADDR_W(ADDR_W), .NUM_GROUPS(NUM_GROUPS), .NUM_PLAIN(NUM_PLAIN)
  ) decode_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqBe(reqBe), .stb(stb),
    .rspValid(rspValid), .rspErr(rspErr)
  );

  alias_reg_store #(
    .NUM_GROUPS(NUM_GROUPS), .NUM_PLAIN(NUM_PLAIN), .LOCK_BIT(LOCK_BIT),
    .PLL_MASK(PLL_MASK), .GRP_RESET(GRP_RESET)
  ) store_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(reqWdata),
    .grpVal(grpVal), .rdData(rspRdata)
  );

endmodule

// File: rtl/alias_reg_bank_chk.sv
module alias_reg_bank_chk #(
  parameter int ADDR_W     = 8,
  parameter int NUM_GROUPS = 4
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        reqValid,
  input logic                        reqWrite,
  input logic [ADDR_W-1:0]           reqAddr,
  input logic [31:0]                 reqWdata,
  input logic [3:0]                  reqBe,
  input logic                        rspValid,
  input logic [31:0]                 rspRdata,
  input logic                        rspErr,
  input logic [NUM_GROUPS-1:0][31:0] grpVal
);

  logic fullWr;
  logic fullRd;
  logic badBe;
  assign fullWr = reqValid && reqWrite && (reqBe == 4'hF);
  assign fullRd = reqValid && !reqWrite && (reqBe == 4'hF);
  assign badBe  = reqValid && (reqBe != 4'hF);

  p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_no_rsp_when_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  p_bad_be_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    badBe |=> (rspErr && rspRdata == 32'h0));
  p_write_rsp_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> rspRdata == 32'h0);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gChk
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(4 * g);
    p_base_write_r2: assert property (@(posedge clk) disable iff (!rstN)
      (fullWr && reqAddr == BASE) |=> grpVal[g] == $past(reqWdata));
    p_set_alias_r3: assert property (@(posedge clk) disable iff (!rstN)
      (fullWr && reqAddr == BASE + 1'b1)
        |=> grpVal[g] == ($past(grpVal[g]) | $past(reqWdata)));
    p_clr_alias_r4: assert property (@(posedge clk) disable iff (!rstN)
      (fullWr && reqAddr == BASE + 2'd2)
        |=> grpVal[g] == ($past(grpVal[g]) & ~$past(reqWdata)));
    p_tog_alias_r5: assert property (@(posedge clk) disable iff (!rstN)
      (fullWr && reqAddr == BASE + 2'd3)
        |=> grpVal[g] == ($past(grpVal[g]) ^ $past(reqWdata)));
    p_alias_read_r6: assert property (@(posedge clk) disable iff (!rstN)
      (fullRd && reqAddr[ADDR_W-1:2] == BASE[ADDR_W-1:2])
        |=> rspRdata == $past(grpVal[g]));
    p_bad_be_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
      badBe |=> $stable(grpVal[g]));
  end

endmodule

bind alias_reg_bank alias_reg_bank_chk #(
  .ADDR_W(ADDR_W), .NUM_GROUPS(NUM_GROUPS)
) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
  .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr),
  .grpVal(grpVal)
);

// File: tb/alias_reg_bank_tb_top.sv
module alias_reg_bank_tb_top;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic [3:0]  be;
    logic [31:0] exp;
    logic        err;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd0,  32'h0,         4'hF, 32'h8001_3001, 1'b0, 8'd8},  // R8 PLL lock forced
    '{1'b0, 8'd4,  32'h0,         4'hF, 32'h8001_2000, 1'b0, 8'd8},  // R8
    '{1'b0, 8'd8,  32'h0,         4'hF, 32'h1018_101B, 1'b0, 8'd8},  // R8 no lock
    '{1'b0, 8'd12, 32'h0,         4'hF, 32'h0000_0000, 1'b0, 8'd8},  // R8
    '{1'b0, 8'd16, 32'h0,         4'hF, 32'h0000_0000, 1'b0, 8'd8},  // R8 plain
    '{1'b0, 8'd2,  32'h0,         4'hF, 32'h8001_3001, 1'b0, 8'd6},  // R6 alias read
    '{1'b1, 8'd1,  32'h0000_00F0, 4'hF, 32'h0,         1'b0, 8'd3},  // R3 set
    '{1'b0, 8'd0,  32'h0,         4'hF, 32'h8001_30F1, 1'b0, 8'd3},  // R3
    '{1'b1, 8'd2,  32'h8000_0001, 4'hF, 32'h0,         1'b0, 8'd4},  // R4 clr
    '{1'b0, 8'd3,  32'h0,         4'hF, 32'h0001_30F0, 1'b0, 8'd4},  // R4 R6
    '{1'b1, 8'd3,  32'h0000_FFFF, 4'hF, 32'h0,         1'b0, 8'd5},  // R5 tog
    '{1'b0, 8'd0,  32'h0,         4'hF, 32'h0001_CF0F, 1'b0, 8'd5},  // R5
    '{1'b1, 8'd4,  32'h1234_5678, 4'hF, 32'h0,         1'b0, 8'd2},  // R2 base write
    '{1'b0, 8'd5,  32'h0,         4'hF, 32'h1234_5678, 1'b0, 8'd2},  // R2 R6
    '{1'b1, 8'd15, 32'hA5A5_A5A5, 4'hF, 32'h0,         1'b0, 8'd1},  // R1 last group tog
    '{1'b0, 8'd12, 32'h0,         4'hF, 32'hA5A5_A5A5, 1'b0, 8'd1},  // R1
    '{1'b1, 8'd14, 32'h0000_FFFF, 4'hF, 32'h0,         1'b0, 8'd4},  // R4
    '{1'b0, 8'd13, 32'h0,         4'hF, 32'hA5A5_0000, 1'b0, 8'd4},  // R4 R6
    '{1'b1, 8'd17, 32'hDEAD_BEEF, 4'hF, 32'h0,         1'b0, 8'd7},  // R7 plain write
    '{1'b0, 8'd17, 32'h0,         4'hF, 32'hDEAD_BEEF, 1'b0, 8'd7},  // R7
    '{1'b0, 8'd16, 32'h0,         4'hF, 32'h0000_0000, 1'b0, 8'd7},  // R7 neighbour
    '{1'b1, 8'd9,  32'hFFFF_FFFF, 4'h3, 32'h0,         1'b1, 8'd10}, // R10 partial write
    '{1'b0, 8'd8,  32'h0,         4'hF, 32'h1018_101B, 1'b0, 8'd10}, // R10 unchanged
    '{1'b0, 8'd8,  32'h0,         4'h7, 32'h0,         1'b1, 8'd10}, // R10 partial read
    '{1'b1, 8'd20, 32'hFFFF_FFFF, 4'hF, 32'h0,         1'b0, 8'd11}, // R11 unmapped
    '{1'b0, 8'd20, 32'h0,         4'hF, 32'h0,         1'b0, 8'd11}, // R11
    '{1'b1, 8'd10, 32'h0000_001B, 4'hF, 32'h0,         1'b0, 8'd4},  // R4 R12
    '{1'b0, 8'd11, 32'h0,         4'hF, 32'h1018_1000, 1'b0, 8'd4},  // R4
    '{1'b0, 8'd0,  32'h0,         4'hF, 32'h0001_CF0F, 1'b0, 8'd9}   // R9 state kept
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  reqBe = '0;
  logic        rspValid;
  logic [31:0] rspRdata;
  logic        rspErr;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alias_reg_bank dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drives at a falling edge; returns one cycle later with the response visible.
  task automatic issue(logic wr, logic [7:0] addr, logic [31:0] wd, logic [3:0] be);
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = addr;
    reqWdata = wd;
    reqBe    = be;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 idle after reset rspValid", 32'(rspValid), 32'h0);
    check("R9 idle after reset rspErr", 32'(rspErr), 32'h0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].wr, VECS[i].addr, VECS[i].wd, VECS[i].be);
      check($sformatf("R%0d vec %0d data", VECS[i].req, i), rspRdata, VECS[i].exp);
      check($sformatf("R%0d vec %0d err", VECS[i].req, i), 32'(rspErr), 32'(VECS[i].err));
      check($sformatf("R9 vec %0d rspValid", i), 32'(rspValid), 32'h1);
    end

    // R9: no response in an idle cycle
    @(negedge clk);
    check("R9 idle rspValid", 32'(rspValid), 32'h0);

    // R8: reset in mid-run restores values and lock bits
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    issue(1'b0, 8'd0, 32'h0, 4'hF);
    check("R8 group0 after re-reset", rspRdata, 32'h8001_3001);
    issue(1'b0, 8'd7, 32'h0, 4'hF);
    check("R8 group1 after re-reset via alias", rspRdata, 32'h8001_2000);
    issue(1'b0, 8'd17, 32'h0, 4'hF);
    check("R8 plain1 after re-reset", rspRdata, 32'h0);

    // R3 R5: clearing the lock bit by toggle, then setting it back
    issue(1'b1, 8'd3, 32'h8000_0000, 4'hF);
    issue(1'b0, 8'd0, 32'h0, 4'hF);
    check("R5 lock toggled off", rspRdata, 32'h0001_3001);
    issue(1'b1, 8'd1, 32'h8000_0000, 4'hF);
    issue(1'b0, 8'd1, 32'h0, 4'hF);
    check("R3 lock set again", rspRdata, 32'h8001_3001);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule